// File: doc/BRIEF.md
# LPDDR2 Power-Up Delay Sequencer

This block runs the timing phase that an LPDDR2 device needs after power is applied and before any mode register can be programmed. It waits until the clock source reports lock. It then counts cycles of its own (divided) clock to meet each mandatory wait. It raises clock enable, sends one mode-register-write reset command on the double-edge command/address bus, and waits out the reset recovery and a final settle time. At the end it reports completion.

The four wait lengths are parameters in clock cycles, and so is the don't-care operand byte of the reset command. Once the sequence has started it runs to completion without looking at the lock input again. Only the asynchronous reset returns it to idle. Downstream logic, such as mode-register and calibration sequencers, starts from the done flag or the done pulse.

Top module: `lp2_pwrup_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first clock edge that samples `pll_lock_i` high, the block holds `cke_o`=0, `cs_n_o`=1, `done_o`=0, `done_pulse_o`=0 and drives the idle command (see R5).
- R2: The first rising edge after reset release that samples `pll_lock_i` high is the start edge. `cke_o` goes high exactly `T_PWR` cycles after the start edge.
- R3: `cs_n_o` goes low exactly `T_CKE` cycles after `cke_o` rises, and stays low for exactly one cycle.
- R4: During the cycle with `cs_n_o` low, `ca_rise_o` is 10'h3F0: bits 3..0 are zero and bits 9..4 carry register address bits 5..0 of 8'h3F. `ca_fall_o` carries address bits 7..6 (zero) in bits 1..0 and the operand parameter `RST_OP` in bits 9..2.
- R5: In every cycle with `cs_n_o` high, `ca_rise_o` is 10'h007 (bits 2..0 high) and `ca_fall_o` is 10'h000.
- R6: `done_o` goes high exactly `1+T_RST+T_SETTLE` cycles after `cs_n_o` falls, and stays high until reset.
- R7: `done_pulse_o` is high for exactly one cycle, which is the first cycle in which `done_o` is high.
- R8: Once `cke_o` is high it stays high until reset, and `cs_n_o` is never low while `cke_o` is low.
- R9: A drop of `pll_lock_i` after the start edge does not change the timing of any output.
- R10: Exactly one command (one `cs_n_o` low cycle) is issued per sequence.
- R11: An asynchronous reset at any point of the sequence returns all outputs to the R1 state at once. A later start replays every wait in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided clock that all waits are counted in |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 1 | Clock source locked; starts the sequence |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Memory chip select, active low |
| ca_rise_o | output | 10 | Command/address word for the rising clock edge |
| ca_fall_o | output | 10 | Command/address word for the falling clock edge |
| done_o | output | 1 | Power-up phase complete, held until reset |
| done_pulse_o | output | 1 | One-cycle strobe on completion |

## Verification
On every cycle the assertions enforce the following:
- chip select is never active without clock enable;
- clock enable never drops and the command lasts one cycle;
- the command word appears only under chip select, with the idle word at all other times;
- done is sticky and the pulse coincides with its rising edge.

The exact lengths of the four waits can only be shown by the bench scenarios. The same holds for indifference to a lock drop after start, for the single command per run and for restart after a mid-sequence reset. There, a cycle-accurate reference model tracks elapsed cycles since the start edge.

// File: rtl/lp2_pwrup_pkg.sv
package lp2_pwrup_pkg;

  localparam int CA_W = 10;
  localparam logic [7:0] MRW_RESET_MA = 8'h3F;
  localparam logic [CA_W-1:0] NOP_RISE = 10'h007;
  localparam logic [CA_W-1:0] NOP_FALL = 10'h000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_CKE,
    ST_CMD,
    ST_RST,
    ST_SETTLE,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic [CA_W-1:0] rise;
    logic [CA_W-1:0] fall;
  } ca_pair_t;

  // mode-register write: address split over both edges, operand on fall
  function automatic ca_pair_t mrw_word(input logic [7:0] ma, input logic [7:0] op);
    ca_pair_t w;
    w.rise = {ma[5:0], 4'b0000};
    w.fall = {op, ma[7:6]};
    return w;
  endfunction

endpackage

// File: rtl/lp2_wait_cnt.sv
module lp2_wait_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // a new wait may only be armed once the previous one has expired
  a_r2_load_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o);

endmodule

// File: rtl/lp2_ca_enc.sv
module lp2_ca_enc
  import lp2_pwrup_pkg::*;
#(
  parameter logic [7:0] RST_OP = 8'h00
) (
  input  logic            cmd_i,
  output logic [CA_W-1:0] ca_rise_o,
  output logic [CA_W-1:0] ca_fall_o
);

  ca_pair_t w;

  always_comb begin
    if (cmd_i) w = mrw_word(MRW_RESET_MA, RST_OP);
    else       w = '{rise: NOP_RISE, fall: NOP_FALL};
  end

  assign ca_rise_o = w.rise;
  assign ca_fall_o = w.fall;

endmodule

// File: rtl/lp2_pwrup_seq.sv
module lp2_pwrup_seq
  import lp2_pwrup_pkg::*;
#(
  parameter int unsigned T_PWR    = 200,
  parameter int unsigned T_CKE    = 100,
  parameter int unsigned T_RST    = 50,
  parameter int unsigned T_SETTLE = 80,
  parameter logic [7:0]  RST_OP   = 8'h00
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pll_lock_i,
  output logic            cke_o,
  output logic            cs_n_o,
  output logic [CA_W-1:0] ca_rise_o,
  output logic [CA_W-1:0] ca_fall_o,
  output logic            done_o,
  output logic            done_pulse_o
);

  localparam int unsigned T_MAX_A = (T_PWR > T_CKE) ? T_PWR : T_CKE;
  localparam int unsigned T_MAX_B = (T_RST > T_SETTLE) ? T_RST : T_SETTLE;
  localparam int unsigned T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  seq_st_e          state_q, state_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic             pulse_q;
  logic             cmd;

  lp2_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  // each timed state lasts exactly its parameter: counter armed with N-1 on entry
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: if (pll_lock_i) begin
        state_d  = ST_PWR;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_PWR - 1);
      end
      ST_PWR: if (cnt_zero) begin
        state_d  = ST_CKE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_CKE - 1);
      end
      ST_CKE: if (cnt_zero) state_d = ST_CMD;
      ST_CMD: begin
        state_d  = ST_RST;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_RST - 1);
      end
      ST_RST: if (cnt_zero) begin
        state_d  = ST_SETTLE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_SETTLE - 1);
      end
      ST_SETTLE: if (cnt_zero) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_q == ST_SETTLE) && (state_d == ST_DONE);
    end
  end

  assign cmd          = (state_q == ST_CMD);
  assign cke_o        = (state_q != ST_IDLE) && (state_q != ST_PWR);
  assign cs_n_o       = !cmd;
  assign done_o       = (state_q == ST_DONE);
  assign done_pulse_o = pulse_q;

  lp2_ca_enc #(.RST_OP(RST_OP)) u_ca (
    .cmd_i     (cmd),
    .ca_rise_o (ca_rise_o),
    .ca_fall_o (ca_fall_o)
  );

  a_r8_cs_needs_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> cke_o);

  a_r8_cke_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  a_r3_cmd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |=> cs_n_o);

  a_r3_cke_before_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(cke_o));

  a_r4_reset_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> (ca_rise_o == 10'h3F0) && (ca_fall_o == {RST_OP, 2'b00}));

  a_r5_idle_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (ca_rise_o == NOP_RISE) && (ca_fall_o == NOP_FALL));

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r7_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o == $rose(done_o));

  a_r6_done_needs_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cke_o && cs_n_o);

endmodule

// File: tb/lp2_pwrup_seq_tb.sv
`timescale 1ns/1ps
module lp2_pwrup_seq_tb;

  localparam int TP = 7;
  localparam int TC = 5;
  localparam int TR = 4;
  localparam int TS = 6;
  localparam logic [7:0] OPV = 8'hA5;
  localparam int K_CMD  = TP + TC;
  localparam int K_DONE = TP + TC + 1 + TR + TS;

  logic clk = 1'b0;
  logic rst_n, lock;
  logic cke, cs_n, done, pulse;
  logic [9:0] ca_r, ca_f;

  always #2 clk = ~clk;

  lp2_pwrup_seq #(
    .T_PWR(TP), .T_CKE(TC), .T_RST(TR), .T_SETTLE(TS), .RST_OP(OPV)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pll_lock_i(lock),
    .cke_o(cke), .cs_n_o(cs_n), .ca_rise_o(ca_r), .ca_fall_o(ca_f),
    .done_o(done), .done_pulse_o(pulse)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int cmd_cnt = 0;
  bit cmp_en = 0;

  // reference model: cycles elapsed since the start edge
  bit started;
  int k;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 0;
      k <= 0;
    end else if (!started) begin
      if (lock) begin
        started <= 1;
        k <= 0;
      end
    end else begin
      k <= k + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      bit e_cke, e_cmd, e_done, e_pulse;
      logic [9:0] e_r, e_f;
      e_cke   = started && (k >= TP);
      e_cmd   = started && (k == K_CMD);
      e_done  = started && (k >= K_DONE);
      e_pulse = started && (k == K_DONE);
      e_r = e_cmd ? 10'h3F0 : 10'h007;
      e_f = e_cmd ? {OPV, 2'b00} : 10'h000;
      chk(cke == e_cke, "R2 cke", 32'(cke), 32'(e_cke));
      chk(cs_n == !e_cmd, "R3 cs_n", 32'(cs_n), 32'(!e_cmd));
      chk(ca_r == e_r, e_cmd ? "R4 ca_rise" : "R5 ca_rise", 32'(ca_r), 32'(e_r));
      chk(ca_f == e_f, e_cmd ? "R4 ca_fall" : "R5 ca_fall", 32'(ca_f), 32'(e_f));
      chk(done == e_done, "R6 done", 32'(done), 32'(e_done));
      chk(pulse == e_pulse, "R7 done_pulse", 32'(pulse), 32'(e_pulse));
      if (!cs_n) cmd_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_err++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    #0.5;
    chk(!cke && cs_n && !done && !pulse && ca_r == 10'h007, tag,
        32'({cke, cs_n, done, pulse}), 32'(4'b0100));
  endtask

  initial begin
    rst_n = 1'b0;
    lock  = 1'b0;
    step(2);
    cmp_en = 1;
    step(3);
    idle_chk("R1 in reset");
    // reset released, lock still low
    rst_n = 1'b1;
    step(10);
    idle_chk("R1 waiting for lock");
    lock = 1'b1;
    step(K_DONE + 6);
    chk(done == 1'b1, "R6 done held", 32'(done), 32'd1);
    chk(cmd_cnt == 1, "R10 one command", 32'(cmd_cnt), 32'd1);

    // R11: reset mid-sequence, lock held high throughout
    rst_n = 1'b0;
    step(2);
    idle_chk("R11 reset after done");
    rst_n = 1'b1;
    step(TP + 2);
    rst_n = 1'b0;
    step(2);
    idle_chk("R11 reset during cke wait");
    cmd_cnt = 0;
    rst_n = 1'b1;
    step(K_DONE + 4);
    chk(done == 1'b1, "R11 done after restart", 32'(done), 32'd1);
    chk(cmd_cnt == 1, "R10 one command after restart", 32'(cmd_cnt), 32'd1);

    // R9: lock drops after start, timing unchanged
    rst_n = 1'b0;
    step(2);
    cmd_cnt = 0;
    rst_n = 1'b1;
    step(TP + 1);
    lock = 1'b0;
    step(K_DONE + 4);
    chk(done == 1'b1, "R9 done despite lock loss", 32'(done), 32'd1);
    chk(cmd_cnt == 1, "R9 command despite lock loss", 32'(cmd_cnt), 32'd1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule